// File: doc/BRIEF.md
# ATA Task-File Status and Control

This block is the device side of an ATA-style register file. A host reaches it through a small register bus: a 4-bit offset, read and write strobes, and 8-bit data. On the other side sits an internal storage controller, modelled here as plain level and pulse signals. The block builds the status byte from the controller's busy, ready, seek-complete, data-request, fault, corrected-data and error lines. It serves that byte at two offsets: a primary status read that acknowledges the interrupt, and an alternate read that does not.

The host writes a device control register to request a soft reset and to mask the interrupt. That register is accepted even while the device is busy. Writes to the task-file offsets 0h to 7h are passed to the controller only while the device is not busy. A write that is refused sets a sticky flag. A small state machine, `tf_reset_fsm`, sequences the soft reset. Its states are RS_RUN (normal operation), RS_HOLD (soft reset held) and RS_RECOVER (busy still forced after release). Its transitions are:
- RUN to HOLD, when the reset bit is written as 1.
- HOLD to RECOVER, when the reset bit is written as 0.
- RECOVER to HOLD, when the reset bit is written as 1 again.
- RECOVER to RUN, when the recovery count runs out.

Top module: `ata_taskfile_ctl`

## Requirements
- R1: The status byte holds, from bit 7 down to bit 0: busy, ready, write fault, seek complete, data request, corrected, a constant 0, and error. It is returned on a read of offset 7h (primary status) and of offset Eh (alternate status).
- R2: While the effective busy is 1, a status read returns exactly 80h. Effective busy is the controller busy input OR-ed with the soft-reset state being HOLD or RECOVER.
- R3: A host write to offsets 0h to 7h gives a one-cycle `tf_wr` with the same offset and data when effective busy is 0. The write is dropped when effective busy is 1.
- R4: A dropped task-file write sets `wr_dropped`. The flag stays 1 until the hardware reset.
- R5: A write to offset Eh updates the device control register even while busy. Only bit 2 (soft reset) and bit 1 (interrupt disable) take effect; bits 7 to 3 and bit 0 change nothing.
- R6: `ctl_soft_rst` goes high on the cycle after a write with bit 2 = 1. It stays high until a write with bit 2 = 0. Effective busy then stays 1 for RECOVER_CYCLES more cycles (default 1).
- R7: Device control bit 1 = 1 forces `irq` low. It resets to 0 and is reported on `ien_n`.
- R8: An interrupt event pulse sets a pending flag, which drives `irq` when unmasked. A primary status read clears the flag, and an alternate status read leaves it unchanged. An event in the same cycle as a primary status read leaves the flag set. While `ctl_soft_rst` is high the flag is cleared and events are ignored.
- R9: A read of offset Fh returns `{1'b0, drv_sel_n}` with `rd_oe` = 7Fh, so bit 7 is not driven. Reads of other offsets return 00h with `rd_oe` = FFh. When no read is in progress, `rd_oe` and `host_rdata` are 00h.
- R10: After the hardware reset, `ctl_soft_rst`, `irq`, `ien_n` and `wr_dropped` are 0. With the controller inputs low, a status read returns 00h, so ready reads 0 until the controller raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| host_addr | input | 4 | Register offset |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (combinational) |
| rd_oe | output | 8 | Per-bit drive enable for read data |
| ctl_busy | input | 1 | Controller busy |
| ctl_ready | input | 1 | Controller able to take a command |
| ctl_fault | input | 1 | Write fault |
| ctl_seek_done | input | 1 | Seek complete |
| ctl_drq | input | 1 | Data request |
| ctl_corr | input | 1 | Corrected data error seen |
| ctl_err | input | 1 | Last command ended in error |
| ctl_irq_evt | input | 1 | One-cycle interrupt event |
| drv_sel_n | input | 7 | Active-low write-gate, head and drive select indications |
| tf_wr | output | 1 | Forwarded task-file write strobe |
| tf_addr | output | 4 | Forwarded write offset |
| tf_data | output | 8 | Forwarded write data |
| ctl_soft_rst | output | 1 | Soft reset to the controller |
| irq | output | 1 | Interrupt request |
| ien_n | output | 1 | Current interrupt-disable bit |
| wr_dropped | output | 1 | Sticky refused-write flag |

## Verification
Two pairs of functions can act in the same cycle.

The first pair is the interrupt event and the primary status read that acknowledges it. The bench drives `ctl_irq_evt` and a read of offset 7h together. It then checks that `irq` is still high on the next cycle, which shows that the new event beat the clear.

The second pair is a device control write landing while the device is busy, both in soft-reset hold and under controller busy. In that cycle a task-file write must be refused and the control write must be accepted. The behavioural model in the bench predicts every output each clock, so any disagreement in those cycles is reported.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] OFS_LAST_TF = 4'h7;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 4'h7;
    localparam logic [ADDR_W-1:0] OFS_DEVCTL  = 4'hE;
    localparam logic [ADDR_W-1:0] OFS_DRVADDR = 4'hF;

    localparam int DC_SRST  = 2;
    localparam int DC_IEN_N = 1;

    localparam logic [DATA_W-1:0] STATUS_BUSY = 8'h80;

    typedef enum logic [1:0] {
        RS_RUN     = 2'd0,
        RS_HOLD    = 2'd1,
        RS_RECOVER = 2'd2
    } rst_state_e;
endpackage

// File: rtl/tf_reset_fsm.sv
module tf_reset_fsm
    import ata_tf_pkg::*;
#(
    parameter int RECOVER_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic devctl_wr,
    input  logic srst_bit,
    output logic soft_rst_o,
    output logic hold_busy_o
);
    localparam int CW = $clog2(RECOVER_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(RECOVER_CYCLES);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    rst_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RS_RUN: begin
                if (devctl_wr && srst_bit) state_d = RS_HOLD;
            end
            RS_HOLD: begin
                if (devctl_wr && !srst_bit) begin
                    state_d = RS_RECOVER;
                    cnt_d   = CNT_LOAD;
                end
            end
            RS_RECOVER: begin
                if (devctl_wr && srst_bit) begin
                    state_d = RS_HOLD;
                end else if (cnt_q == CNT_ONE) begin
                    state_d = RS_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            default: state_d = RS_RUN;
        endcase
    end

    always_comb begin
        soft_rst_o  = 1'b0;
        hold_busy_o = 1'b0;
        unique case (state_q)
            RS_RUN:     ;
            RS_HOLD:    begin soft_rst_o = 1'b1; hold_busy_o = 1'b1; end
            RS_RECOVER: hold_busy_o = 1'b1;
            default:    ;
        endcase
    end

    AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_o && !(devctl_wr && !srst_bit)) |=> soft_rst_o); // R6
endmodule

// File: rtl/tf_irq_ctl.sv
module tf_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic stat_rd,
    input  logic flush,
    input  logic devctl_wr,
    input  logic ien_n_bit,
    output logic irq_o,
    output logic ien_n_o
);
    logic pend_q;
    logic ien_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            ien_n_q <= 1'b0;
        end else begin
            if (flush)        pend_q <= 1'b0;
            else if (evt)     pend_q <= 1'b1;
            else if (stat_rd) pend_q <= 1'b0;
            if (devctl_wr) ien_n_q <= ien_n_bit;
        end
    end

    always_comb begin
        irq_o   = pend_q & ~ien_n_q;
        ien_n_o = ien_n_q;
    end

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !flush && !ien_n_q && !devctl_wr) |=> irq_o); // R8
endmodule

// File: rtl/tf_status_mux.sv
module tf_status_mux
    import ata_tf_pkg::*;
(
    input  logic              busy_eff,
    input  logic              ready,
    input  logic              fault,
    input  logic              seek_done,
    input  logic              drq,
    input  logic              corr,
    input  logic              err,
    input  logic [6:0]        drv_sel_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] oe
);
    logic [DATA_W-1:0] status;

    always_comb begin
        if (busy_eff) status = STATUS_BUSY;
        else          status = {1'b0, ready, fault, seek_done, drq, corr, 1'b0, err};
    end

    always_comb begin
        rdata = '0;
        oe    = '0;
        if (rd) begin
            oe = '1;
            unique case (addr)
                OFS_STATUS, OFS_DEVCTL: rdata = status;
                OFS_DRVADDR: begin
                    rdata = {1'b0, drv_sel_n};
                    oe    = 8'h7F;
                end
                default: rdata = '0;
            endcase
        end
    end

    AST_IDX_ZERO: assert final (!(rd && (addr == OFS_STATUS)) || (rdata[1] == 1'b0)); // R1
endmodule

// File: rtl/ata_taskfile_ctl.sv
module ata_taskfile_ctl
    import ata_tf_pkg::*;
#(
    parameter int RECOVER_CYCLES = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  host_addr,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic [7:0]  rd_oe,
    input  logic        ctl_busy,
    input  logic        ctl_ready,
    input  logic        ctl_fault,
    input  logic        ctl_seek_done,
    input  logic        ctl_drq,
    input  logic        ctl_corr,
    input  logic        ctl_err,
    input  logic        ctl_irq_evt,
    input  logic [6:0]  drv_sel_n,
    output logic        tf_wr,
    output logic [3:0]  tf_addr,
    output logic [7:0]  tf_data,
    output logic        ctl_soft_rst,
    output logic        irq,
    output logic        ien_n,
    output logic        wr_dropped
);
    logic hold_busy;
    logic busy_eff;
    logic devctl_wr;
    logic tf_hit;
    logic stat_rd;
    logic drop_q;

    assign devctl_wr = host_wr && (host_addr == OFS_DEVCTL);
    assign tf_hit    = host_wr && (host_addr <= OFS_LAST_TF);
    assign stat_rd   = host_rd && (host_addr == OFS_STATUS);
    assign busy_eff  = ctl_busy | hold_busy;

    tf_reset_fsm #(.RECOVER_CYCLES(RECOVER_CYCLES)) rst_fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .devctl_wr  (devctl_wr),
        .srst_bit   (host_wdata[DC_SRST]),
        .soft_rst_o (ctl_soft_rst),
        .hold_busy_o(hold_busy)
    );

    tf_irq_ctl irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (ctl_irq_evt),
        .stat_rd   (stat_rd),
        .flush     (ctl_soft_rst),
        .devctl_wr (devctl_wr),
        .ien_n_bit (host_wdata[DC_IEN_N]),
        .irq_o     (irq),
        .ien_n_o   (ien_n)
    );

    tf_status_mux mux_i (
        .busy_eff (busy_eff),
        .ready    (ctl_ready),
        .fault    (ctl_fault),
        .seek_done(ctl_seek_done),
        .drq      (ctl_drq),
        .corr     (ctl_corr),
        .err      (ctl_err),
        .drv_sel_n(drv_sel_n),
        .rd       (host_rd),
        .addr     (host_addr),
        .rdata    (host_rdata),
        .oe       (rd_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                drop_q <= 1'b0;
        else if (tf_hit && busy_eff) drop_q <= 1'b1;
    end

    always_comb begin
        tf_wr      = tf_hit && !busy_eff;
        tf_addr    = host_addr;
        tf_data    = host_wdata;
        wr_dropped = drop_q;
    end

    AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && busy_eff) |-> (host_rdata == STATUS_BUSY)); // R2
    AST_NO_FWD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tf_wr |-> !busy_eff); // R3
    AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dropped |=> wr_dropped); // R4
    AST_RECOVER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_soft_rst) |-> busy_eff); // R6
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ien_n |-> !irq); // R7
    AST_DRV_BIT7_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFS_DRVADDR) |-> (rd_oe == 8'h7F)); // R9
endmodule

// File: tb/ata_taskfile_ctl_tb_top.sv
`timescale 1ns/1ps
module ata_taskfile_ctl_tb_top;
    localparam int RC = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] host_addr = '0;
    logic host_rd = 0, host_wr = 0;
    logic [7:0] host_wdata = '0;
    logic ctl_busy = 0, ctl_ready = 0, ctl_fault = 0, ctl_seek_done = 0;
    logic ctl_drq = 0, ctl_corr = 0, ctl_err = 0, ctl_irq_evt = 0;
    logic [6:0] drv_sel_n = '0;
    logic [7:0] host_rdata, rd_oe, tf_data;
    logic [3:0] tf_addr;
    logic tf_wr, ctl_soft_rst, irq, ien_n, wr_dropped;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_state = 0;
    int m_cnt = 0;
    bit m_pend = 0, m_ien_n = 0, m_drop = 0;

    always #2 clk = ~clk;

    ata_taskfile_ctl #(.RECOVER_CYCLES(RC)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rd_oe(rd_oe), .ctl_busy(ctl_busy), .ctl_ready(ctl_ready),
        .ctl_fault(ctl_fault), .ctl_seek_done(ctl_seek_done), .ctl_drq(ctl_drq),
        .ctl_corr(ctl_corr), .ctl_err(ctl_err), .ctl_irq_evt(ctl_irq_evt),
        .drv_sel_n(drv_sel_n), .tf_wr(tf_wr), .tf_addr(tf_addr), .tf_data(tf_data),
        .ctl_soft_rst(ctl_soft_rst), .irq(irq), .ien_n(ien_n), .wr_dropped(wr_dropped)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_busy();
        return ctl_busy || (m_state != 0);
    endfunction

    task automatic model_step();
        bit dev_w, tf_w, busy_old;
        int st_old;
        dev_w = host_wr && (host_addr == 4'hE);
        tf_w = host_wr && (host_addr < 4'h8);
        busy_old = m_busy();
        st_old = m_state;
        if (tf_w && busy_old) m_drop = 1;
        if (dev_w) m_ien_n = host_wdata[1];
        if (st_old == 1) m_pend = 0;
        else if (ctl_irq_evt) m_pend = 1;
        else if (host_rd && host_addr == 4'h7) m_pend = 0;
        case (st_old)
            0: if (dev_w && host_wdata[2]) m_state = 1;
            1: if (dev_w && !host_wdata[2]) begin m_state = 2; m_cnt = RC; end
            default: begin
                if (dev_w && host_wdata[2]) m_state = 1;
                else if (m_cnt == 1) m_state = 0;
                else m_cnt = m_cnt - 1;
            end
        endcase
    endtask

    task automatic compare_all();
        logic [7:0] st, ed, eo;
        string rtag;
        st = m_busy() ? 8'h80 :
             {1'b0, ctl_ready, ctl_fault, ctl_seek_done, ctl_drq, ctl_corr, 1'b0, ctl_err};
        ed = 8'h00; eo = 8'h00; rtag = "R9";
        if (host_rd) begin
            eo = 8'hFF;
            if (host_addr == 4'h7 || host_addr == 4'hE) begin
                ed = st; rtag = m_busy() ? "R2" : "R1";
            end else if (host_addr == 4'hF) begin
                ed = {1'b0, drv_sel_n}; eo = 8'h7F;
            end
        end
        chk(rtag, host_rdata, ed);
        chk("R9 oe", rd_oe, eo);
        chk("R3", {7'b0, tf_wr}, {7'b0, host_wr && host_addr < 4'h8 && !m_busy()});
        if (tf_wr) begin
            chk("R3 addr", {4'b0, tf_addr}, {4'b0, host_addr});
            chk("R3 data", tf_data, host_wdata);
        end
        chk("R4", {7'b0, wr_dropped}, {7'b0, m_drop});
        chk("R6", {7'b0, ctl_soft_rst}, {7'b0, m_state == 1});
        chk("R7", {7'b0, ien_n}, {7'b0, m_ien_n});
        chk("R8", {7'b0, irq}, {7'b0, m_pend && !m_ien_n});
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic bus_idle();
        host_rd = 0; host_wr = 0; ctl_irq_evt = 0;
    endtask

    task automatic do_rd(input logic [3:0] a);
        host_addr = a; host_rd = 1; host_wr = 0;
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        host_addr = a; host_wr = 1; host_rd = 0; host_wdata = d;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        chk("R10 srst", {7'b0, ctl_soft_rst}, 8'h00);
        chk("R10 irq", {7'b0, irq}, 8'h00);
        chk("R10 ien_n", {7'b0, ien_n}, 8'h00);
        chk("R10 drop", {7'b0, wr_dropped}, 8'h00);
        do_rd(4'h7);
        #0.5;
        chk("R10 status", host_rdata, 8'h00);
        tick();

        // R1: status composition across patterns
        for (int p = 0; p < 8; p++) begin
            ctl_ready = 1; ctl_seek_done = p[0]; ctl_fault = p[1];
            ctl_corr = p[2]; ctl_err = p[0] ^ p[2]; ctl_drq = p[1];
            do_rd(p[0] ? 4'hE : 4'h7);
            tick();
        end
        // R9: drive address and other offsets
        drv_sel_n = 7'h55; do_rd(4'hF); tick();
        drv_sel_n = 7'h2A; do_rd(4'hF); tick();
        do_rd(4'h3); tick();
        bus_idle(); tick();

        // R3: forwarded write
        do_wr(4'h3, 8'hAB); tick();
        do_wr(4'h7, 8'h20); tick();
        // R2/R3/R4: controller busy
        ctl_busy = 1;
        do_rd(4'h7); tick();
        do_wr(4'h7, 8'h30); tick();
        // R5: devctl while busy, ignored bits set, bit1 = 1
        do_wr(4'hE, 8'hFB); tick();
        ctl_busy = 0;
        bus_idle(); tick();
        chk("R4 sticky", {7'b0, wr_dropped}, 8'h01);

        // R7: masked event
        ctl_irq_evt = 1; tick();
        bus_idle(); tick();
        chk("R7 masked", {7'b0, irq}, 8'h00);
        do_wr(4'hE, 8'hF9); tick();   // bit2=0 bit1=0, others set
        bus_idle(); tick();
        chk("R5 no srst", {7'b0, ctl_soft_rst}, 8'h00);
        chk("R8 unmasked", {7'b0, irq}, 8'h01);
        // R8: alternate read keeps, primary read clears
        do_rd(4'hE); tick();
        chk("R8 alt keeps", {7'b0, irq}, 8'h01);
        do_rd(4'h7); tick();
        chk("R8 status clears", {7'b0, irq}, 8'h00);
        // R8: event and status read together
        ctl_irq_evt = 1; do_rd(4'h7); tick();
        bus_idle(); tick();
        chk("R8 evt wins", {7'b0, irq}, 8'h01);

        // R6: soft reset hold and recovery
        do_wr(4'hE, 8'h04); tick();
        bus_idle(); tick();
        chk("R8 flush", {7'b0, irq}, 8'h00);
        ctl_irq_evt = 1; tick();
        bus_idle();
        for (int k = 0; k < 4; k++) begin
            do_rd(4'h7); tick();
            chk("R6 held", {7'b0, ctl_soft_rst}, 8'h01);
        end
        do_wr(4'h2, 8'h11); tick();
        do_wr(4'hE, 8'h00); tick();
        chk("R6 released", {7'b0, ctl_soft_rst}, 8'h00);
        do_rd(4'h7); #0.5;
        chk("R6 recover busy", host_rdata, 8'h80);
        tick();
        do_rd(4'h7); tick();
        do_wr(4'h1, 8'h5A); tick();
        // R6: re-enter hold from recovery
        do_wr(4'hE, 8'h04); tick();
        do_wr(4'hE, 8'h00); tick();
        do_wr(4'hE, 8'h04); tick();
        do_wr(4'hE, 8'h00); tick();
        bus_idle();
        repeat (3) tick();
        do_rd(4'h7); tick();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule